// File: doc/BRIEF.md
# Three-Request Arbiter with Selectable Rotation

This block arbitrates between three level-sensitive request lines and answers on three acknowledge lines. In each clock cycle it looks at the pending requests and picks one of them using the current priority order. One clock edge later it raises that line's acknowledge for a single cycle. A request that is still high after its acknowledge has no memory of being served. It simply competes again in the next cycle, so simultaneous requests are served one after another.

A build-time parameter selects the policy. In fixed mode request 1 always beats request 2, and request 2 always beats request 3. In rotating mode the order starts as 1, 2, 3 after reset. Each time a line is served it moves to the back of the order, and the other lines keep their relative positions. For example, serving request 2 from the order 1, 2, 3 gives the order 1, 3, 2. This is not a plain rotation, which would give 3, 1, 2. The reset is asynchronous and active low.

Top module: `tri_arbiter`

## Requirements
- R1: While `rst_n` is low, every acknowledge is 0. This takes effect immediately, without waiting for a clock. Reset also restores the priority order to 1, 2, 3.
- R2: At most one acknowledge bit is high in any cycle.
- R3: When `ack[i]` is high, `req[i]` was high at the previous rising clock edge. Bit 0 is request 1, bit 1 is request 2 and bit 2 is request 3, on both buses.
- R4: If any request is high at a rising edge, exactly one acknowledge is high in the following cycle.
- R5: If no request is high at a rising edge, all acknowledges are low in the following cycle and the priority order does not change.
- R6: With `ROTATE=0`, the granted line is the lowest-numbered pending request (1 over 2 over 3).
- R7: A request held high after its acknowledge is treated as a new request. With `ROTATE=0`, a request 1 held for k cycles receives k consecutive acknowledges.
- R8: With `ROTATE=1`, the order right after reset is 1, 2, 3.
- R9: With `ROTATE=1`, the served line moves to the last place and the remaining lines keep their relative order. With all three requests held from reset, the acknowledges go 1, 2, 3, 1. Serving 2 first and then holding all three gives 1, 3, 2.
- R10: The parameter `ROTATE` selects the policy at elaboration time. A value of 0 gives the fixed order and a value of 1 gives the rotating order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N (3) | Request levels, bit 0 = request 1 |
| ack | output | N (3) | Registered one-hot acknowledge pulses |

## Verification
The assertions check the following on every cycle: acknowledges are one-hot, each acknowledge is backed by a request in the previous cycle, any pending request is granted in the next cycle, and an idle cycle grants nothing and leaves the order untouched. In rotating mode they also check that the line just acknowledged sits last in the order. The actual sequence of winners must be shown by the bench scenarios. These include the fixed-order preference, the repeated grant of a held request, the 1, 3, 2 order that separates move-to-back from plain rotation, and the order being restored by an asynchronous reset in mid-run.

// File: rtl/tri_arbiter.sv
module tri_arbiter #(
  parameter int N      = 3,
  parameter bit ROTATE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] ack
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0][IW-1:0] ord_q, ord_d;
  logic [N-1:0]         hit;
  logic [IW-1:0]        win_pos, win_id;
  logic                 found;

  always_comb
    for (int p = 0; p < N; p++) hit[p] = req[ord_q[p]];

  always_comb begin
    found   = 1'b0;
    win_pos = '0;
    for (int p = N-1; p >= 0; p--)
      if (hit[p]) begin
        found   = 1'b1;
        win_pos = IW'(p);
      end
  end

  assign win_id = ord_q[win_pos];

  always_comb begin
    for (int p = 0; p < N-1; p++)
      ord_d[p] = (p < int'(win_pos)) ? ord_q[p] : ord_q[p+1];
    ord_d[N-1] = win_id;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack <= '0;
      for (int p = 0; p < N; p++) ord_q[p] <= IW'(p);
    end else begin
      ack <= found ? (N'(1) << win_id) : '0;
      if (ROTATE && found) ord_q <= ord_d;
    end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  p_backed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack & ~$past(req)) == '0);

  p_serve_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |=> $onehot(ack));

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req) |=> (ack == '0) && $stable(ord_q));

  generate
    if (ROTATE) begin : g_rot
      for (genvar i = 0; i < N; i++) begin : g_line
        p_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
          ack[i] |-> (ord_q[N-1] == IW'(i)));
      end
    end else begin : g_fix
      p_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |=> ack[0]);
    end
  endgenerate
endmodule

// File: tb/sim_tri_arbiter.sv
`timescale 1ns/1ps
module sim_tri_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req = '0;
  logic [2:0] ack_f, ack_r;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  logic [2:0] q_f[$], q_r[$];
  string      t_f[$], t_r[$];
  int         mord[3];

  always #4 clk = ~clk;

  tri_arbiter #(.N(3), .ROTATE(1'b0)) u0 (.clk(clk), .rst_n(rst_n), .req(req), .ack(ack_f));
  tri_arbiter #(.N(3), .ROTATE(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .req(req), .ack(ack_r));

  function automatic logic [2:0] fixed_pick(logic [2:0] r);
    if (r[0]) return 3'b001;
    if (r[1]) return 3'b010;
    if (r[2]) return 3'b100;
    return 3'b000;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 3; k++) mord[k] = k;
  endtask

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ack=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(logic [2:0] r, string tag);
    logic [2:0] er;
    int pos;
    @(negedge clk);
    req = r;
    q_f.push_back(fixed_pick(r)); t_f.push_back({tag, " fixed"});
    pos = -1;
    for (int k = 2; k >= 0; k--) if (r[mord[k]]) pos = k;
    er = '0;
    if (pos >= 0) begin
      int w = mord[pos];
      er[w] = 1'b1;
      for (int k = pos; k < 2; k++) mord[k] = mord[k+1];
      mord[2] = w;
    end
    q_r.push_back(er); t_r.push_back({tag, " rotate"});
  endtask

  always @(posedge clk) begin
    #2;
    if (q_f.size() > 0) check(t_f.pop_front(), ack_f, q_f.pop_front());
    if (q_r.size() > 0) check(t_r.pop_front(), ack_r, q_r.pop_front());
  end

  task automatic do_reset(string tag);
    @(negedge clk);
    req = '0;
    #1 rst_n = 1'b0;
    #1;
    check({tag, " R1 fixed async"}, ack_f, 3'b000);
    check({tag, " R1 rotate async"}, ack_r, 3'b000);
    model_reset();
    @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: expired, actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    #10;
    check("R1 reset fixed", ack_f, 3'b000);
    check("R1 reset rotate", ack_r, 3'b000);
    @(negedge clk); #1 rst_n = 1'b1;

    step(3'b000, "R5 idle");
    step(3'b000, "R5 idle");
    step(3'b001, "R3 R4 single1");
    step(3'b000, "R5 idle");
    step(3'b010, "R3 R4 single2");
    step(3'b100, "R3 R4 single3");
    step(3'b000, "R5 idle");

    do_reset("mid");
    for (int k = 0; k < 4; k++) step(3'b111, "R6 R7 R8 R9 R10 all");
    step(3'b110, "R6 R9 pair23");
    step(3'b110, "R6 R9 pair23");
    step(3'b000, "R5 idle");

    do_reset("again");
    step(3'b010, "R8 R9 serve2");
    step(3'b000, "R5 order kept");
    step(3'b111, "R9 move-to-back");
    step(3'b111, "R9 move-to-back");
    step(3'b111, "R9 move-to-back");
    step(3'b101, "R6 R9 pair13");
    step(3'b101, "R6 R9 pair13");

    do_reset("restore");
    step(3'b001, "R7 held1");
    step(3'b001, "R7 held1");
    step(3'b001, "R7 held1");
    step(3'b111, "R1 R8 order restored");
    step(3'b111, "R1 R8 order restored");
    step(3'b000, "R5 idle");
    @(negedge clk); @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule